// File: doc/BRIEF.md
# Run-Time Precision Packed Dot-Product Accumulator

This block takes two 32-bit words, splits each into packed integer elements, multiplies the elements that share a lane position, adds all lane products together and adds that total to a 32-bit accumulator value. The result appears in a register one clock later. One datapath serves four element widths: 16, 8, 4 and 2 bits. A 2-bit setting, normally held in a control/status register that software writes before a run, selects the width. A single dot-product operation therefore covers every precision.

Each operand has its own signedness flag. Signed and unsigned elements can therefore be mixed in one product, for example signed weights against unsigned activations. The sum wraps modulo 2^32 and never saturates. Instruction decode, register file access and pipeline hazards belong to the surrounding core.

Top module: `simd_dotp_unit`

## Requirements
- R1: While `rstN` is low, `outValid` is 0 and `result` is 0.
- R2: `outValid` is 1 exactly in the cycle after a cycle in which `inValid` was 1 at the clock edge, and 0 otherwise.
- R3: With `precSel` = 2'b00, each operand holds two 16-bit elements, element i in bits [16i+15:16i]. `result` = `accIn` + sum of products of elements at the same position.
- R4: With `precSel` = 2'b01, each operand holds four 8-bit elements, element i in bits [8i+7:8i], combined as in R3.
- R5: With `precSel` = 2'b10, each operand holds eight 4-bit elements, element i in bits [4i+3:4i], combined as in R3.
- R6: With `precSel` = 2'b11, each operand holds sixteen 2-bit elements, element i in bits [2i+1:2i]. A signed element ranges over -2..1 and an unsigned element over 0..3.
- R7: When `signA` is 1, the elements of `opA` are read as two's complement; when it is 0 they are read as unsigned. `signB` does the same for `opB`, independently of `signA`.
- R8: The addition wraps modulo 2^32 with no saturation.
- R9: If either operand is zero, `result` equals `accIn` in every precision and signedness setting.
- R10: While `inValid` is 0, `result` holds its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation strobe; inputs are sampled when high |
| opA | input | 32 | Packed operand A |
| opB | input | 32 | Packed operand B |
| accIn | input | 32 | Scalar accumulator input |
| precSel | input | 2 | Element width: 00=16, 01=8, 10=4, 11=2 bits |
| signA | input | 1 | 1 = elements of opA are signed |
| signB | input | 1 | 1 = elements of opB are signed |
| outValid | output | 1 | Result valid, one cycle after inValid |
| result | output | 32 | Registered accumulated dot product |

## Verification
The hardest case to reach from the ports is a set of lane products whose signs depend on the sign bit of each element under mixed signedness. A wrong sign extension in one lane of one width can hide behind the other lanes. The 2-bit mode is therefore swept exhaustively: every pair of element values is replicated across all sixteen lanes under all four signedness combinations. The three wider modes get many pseudo-random operand pairs under every signedness combination, together with fixed extreme patterns such as all-minimum signed 16-bit elements and an all-ones accumulator, which drive the sum across the 2^32 wrap.

// File: rtl/simd_dotp_pkg.sv
`timescale 1ns/1ps
package simd_dotp_pkg;
  localparam int PREC_N = 4;

  typedef enum logic [1:0] {
    PREC_16 = 2'b00,
    PREC_8  = 2'b01,
    PREC_4  = 2'b10,
    PREC_2  = 2'b11
  } prec_e;

  typedef struct packed {
    logic              capture;
    logic [PREC_N-1:0] laneSel;
  } dotp_strobe_t;
endpackage

// File: rtl/simd_dotp_ctrl.sv
`timescale 1ns/1ps
module simd_dotp_ctrl
  import simd_dotp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [1:0]   precSel,
  output dotp_strobe_t strobe,
  output logic         outValid
);
  // Decode the precision setting into a one-hot lane-width select.
  always_comb begin
    strobe.capture = inValid;
    strobe.laneSel = '0;
    for (int k = 0; k < PREC_N; k++) begin
      if (precSel == 2'(k)) strobe.laneSel[k] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/simd_dotp_datapath.sv
`timescale 1ns/1ps
module simd_dotp_datapath
  import simd_dotp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 32,
  parameter int MAX_EW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dotp_strobe_t      strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [ACC_W-1:0]  accIn,
  input  logic              signA,
  input  logic              signB,
  output logic [ACC_W-1:0]  result
);
  logic [ACC_W-1:0] widthSum [PREC_N];

  // One reduction tree per element width; each is built from the same template.
  for (genvar k = 0; k < PREC_N; k++) begin : g_width
    localparam int EW = MAX_EW >> k;
    localparam int N  = DATA_W / EW;
    localparam int PW = 2 * EW + 2;
    logic [ACC_W-1:0] laneTotal;

    always_comb begin
      laneTotal = '0;
      for (int i = 0; i < N; i++) begin
        automatic logic [EW-1:0]        eA = opA[i*EW +: EW];
        automatic logic [EW-1:0]        eB = opB[i*EW +: EW];
        automatic logic signed [EW:0]   xA = {signA & eA[EW-1], eA};
        automatic logic signed [EW:0]   xB = {signB & eB[EW-1], eB};
        automatic logic signed [PW-1:0] prod = xA * xB;
        laneTotal = laneTotal + ACC_W'(prod);
      end
    end

    assign widthSum[k] = laneTotal;
  end

  logic [ACC_W-1:0] picked;
  always_comb begin
    picked = '0;
    for (int k = 0; k < PREC_N; k++) begin
      if (strobe.laneSel[k]) picked = picked | widthSum[k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               result <= '0;
    else if (strobe.capture) result <= accIn + picked;
  end
endmodule

// File: rtl/simd_dotp_unit.sv
`timescale 1ns/1ps
module simd_dotp_unit
  import simd_dotp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [31:0] accIn,
  input  logic [1:0]  precSel,
  input  logic        signA,
  input  logic        signB,
  output logic        outValid,
  output logic [31:0] result
);
  dotp_strobe_t strobe;

  simd_dotp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .precSel(precSel),
    .strobe(strobe), .outValid(outValid)
  );

  simd_dotp_datapath #(.DATA_W(32), .ACC_W(32), .MAX_EW(16)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opA(opA), .opB(opB),
    .accIn(accIn), .signA(signA), .signB(signB), .result(result)
  );
endmodule

// File: rtl/simd_dotp_checker.sv
`timescale 1ns/1ps
module simd_dotp_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] opA,
  input logic [31:0] opB,
  input logic [31:0] accIn,
  input logic [1:0]  precSel,
  input logic        signA,
  input logic        signB,
  input logic        outValid,
  input logic [31:0] result
);
  // R2: a strobe is answered in the very next cycle
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R2: no answer without a strobe
  p_valid_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R10: result holds while idle
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result));
  // R9: zero operand A passes the accumulator through
  p_zero_a_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opA == 32'd0) |=> (result == $past(accIn)));
  // R9: zero operand B passes the accumulator through
  p_zero_b_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opB == 32'd0) |=> (result == $past(accIn)));
  // R4: unsigned 8-bit times all-ones bytes gives the byte sum of A
  p_byte_sum_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && precSel == 2'b01 && !signA && !signB && opB == 32'h01010101)
    |=> (result == $past(accIn + 32'(opA[7:0]) + 32'(opA[15:8])
                         + 32'(opA[23:16]) + 32'(opA[31:24]))));
endmodule

bind simd_dotp_unit simd_dotp_checker u_chk (.*);

// File: tb/simd_dotp_unit_bench.sv
`timescale 1ns/1ps
module simd_dotp_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0, opB = '0, accIn = '0;
  logic [1:0]  precSel = '0;
  logic        signA = 1'b0, signB = 1'b0;
  logic        outValid;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  simd_dotp_unit u_simd_dotp_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .accIn(accIn), .precSel(precSel), .signA(signA), .signB(signB),
    .outValid(outValid), .result(result)
  );

  function automatic logic [31:0] refDot(input logic [31:0] a, input logic [31:0] b,
      input logic [31:0] acc, input logic [1:0] prec, input logic sa, input logic sb);
    int ew = 16 >> prec;
    int n = 32 / ew;
    longint s = longint'(acc);
    longint span = longint'(1) << ew;
    for (int i = 0; i < n; i++) begin
      longint ea = (longint'(a) >> (i * ew)) & (span - 1);
      longint eb = (longint'(b) >> (i * ew)) & (span - 1);
      if (sa && ea >= span / 2) ea = ea - span;
      if (sb && eb >= span / 2) eb = eb - span;
      s = s + ea * eb;
    end
    return s[31:0];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one operation, then sample one cycle after the capturing edge.
  task automatic runOp(input string tag, input logic [31:0] a, input logic [31:0] b,
      input logic [31:0] acc, input logic [1:0] prec, input logic sa, input logic sb,
      input logic [31:0] exp);
    @(negedge clk);
    opA = a; opB = b; accIn = acc; precSel = prec; signA = sa; signB = sb;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " outValid R2"}, 32'(outValid), 32'd1);
    check(tag, result, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] last;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 outValid", 32'(outValid), 32'd0);
    check("R1 result", result, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 idle outValid", 32'(outValid), 32'd0);

    // R3 / R7 fixed 16-bit patterns
    runOp("R3 signed16",   32'hFFFF0003, 32'h00020005, 32'd100, 2'b00, 1'b1, 1'b1, 32'd113);
    runOp("R3 unsigned16", 32'hFFFF0003, 32'h00020005, 32'd100, 2'b00, 1'b0, 1'b0, 32'd131185);
    // R6 / R7 fixed 2-bit patterns: element 2'b10 everywhere
    runOp("R6 both signed",  32'hAAAAAAAA, 32'hAAAAAAAA, 32'd0, 2'b11, 1'b1, 1'b1, 32'd64);
    runOp("R7 mixed sA",     32'hAAAAAAAA, 32'hAAAAAAAA, 32'd0, 2'b11, 1'b1, 1'b0, 32'hFFFFFFC0);
    runOp("R7 mixed sB",     32'hAAAAAAAA, 32'hFFFFFFFF, 32'd0, 2'b11, 1'b0, 1'b1, 32'hFFFFFFE0);
    // R8 wrap
    runOp("R8 wrap acc",  32'h00000001, 32'h00000002, 32'hFFFFFFFF, 2'b00, 1'b0, 1'b0, 32'd1);
    runOp("R8 wrap prod", 32'h80008000, 32'h80008000, 32'h80000000, 2'b00, 1'b1, 1'b1, 32'd0);
    // R9 zero operand
    runOp("R9 zeroA", 32'd0, 32'hDEADBEEF, 32'h12345678, 2'b10, 1'b1, 1'b0, 32'h12345678);
    runOp("R9 zeroB", 32'hCAFEF00D, 32'd0, 32'h0BADF00D, 2'b01, 1'b0, 1'b1, 32'h0BADF00D);

    // R10: idle cycles with changing inputs leave result alone
    last = result;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      opA = $urandom; opB = $urandom; accIn = $urandom; precSel = 2'(c);
      check("R10 hold", result, last);
      check("R2 quiet", 32'(outValid), 32'd0);
    end

    // R6 exhaustive 2-bit sweep, value pairs replicated in all lanes
    for (int s = 0; s < 4; s++) begin
      for (int ea = 0; ea < 4; ea++) begin
        for (int eb = 0; eb < 4; eb++) begin
          logic [31:0] a = {16{2'(ea)}};
          logic [31:0] b = {16{2'(eb)}};
          logic [31:0] acc = $urandom;
          runOp("R6 sweep", a, b, acc, 2'b11, s[1], s[0],
                refDot(a, b, acc, 2'b11, s[1], s[0]));
        end
      end
    end

    // R3 R4 R5 R7 pseudo-random sweeps in every width and sign combination
    for (int p = 0; p < 3; p++) begin
      for (int s = 0; s < 4; s++) begin
        for (int t = 0; t < 150; t++) begin
          logic [31:0] a = $urandom;
          logic [31:0] b = $urandom;
          logic [31:0] acc = $urandom;
          string tag = (p == 0) ? "R3 rand16" : (p == 1) ? "R4 rand8" : "R5 rand4";
          runOp(tag, a, b, acc, 2'(p), s[1], s[0], refDot(a, b, acc, 2'(p), s[1], s[0]));
        end
      end
    end

    // R4 unsigned byte sum with all-ones bytes
    runOp("R4 bytes", 32'h10203040, 32'h01010101, 32'd5, 2'b01, 1'b0, 1'b0, 32'd165);
    // R5 signed 4-bit: 8 lanes of (-8)*(-8)
    runOp("R5 min4", 32'h88888888, 32'h88888888, 32'd0, 2'b10, 1'b1, 1'b1, 32'd512);

    // R2: back-to-back strobes each give a result
    @(negedge clk);
    opA = 32'h00010001; opB = 32'h00030004; accIn = 32'd0; precSel = 2'b00;
    signA = 1'b0; signB = 1'b0; inValid = 1'b1;
    @(negedge clk);
    check("R2 b2b first valid", 32'(outValid), 32'd1);
    check("R3 b2b first", result, 32'd7);
    accIn = 32'd10;
    @(negedge clk);
    inValid = 1'b0;
    check("R2 b2b second valid", 32'(outValid), 32'd1);
    check("R3 b2b second", result, 32'd17);
    @(negedge clk);
    check("R2 b2b drop", 32'(outValid), 32'd0);

    // R1: reset mid-run clears state
    rstN = 1'b0;
    @(negedge clk);
    check("R1 re-reset result", result, 32'd0);
    check("R1 re-reset valid", 32'(outValid), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule